// File: doc/BRIEF.md
# Buffered Serial Port with Fill-Level Status

This block is an asynchronous serial transmitter and receiver that sits behind a small word-wide register port. Bytes written by software go into a transmit queue and leave on `txd` as framed characters. Characters that arrive on `rxd` are checked and stored in a receive queue, from which software reads them. The serial rate comes from a programmable clock divider. The divider produces a sample tick at eight times the bit rate. Programming the divider to zero freezes every serial state machine in place.

A frame is one low start bit, eight data bits sent least significant bit first, an optional parity bit and one high stop bit. Parity is even or odd under software control. A loopback switch routes the transmitter into the receiver and holds `txd` high. The status word reports the live fill count of each queue along with empty, half-full and full indications. It also reports four sticky receive error flags: break, overrun, parity and framing.

Inside the block, each queue is a valid/ready stream. A push completes only when ready is high, and a pop completes only when valid is high. The register port has no stall. A write to a full transmit queue is discarded, and a read from an empty receive queue returns zero and removes nothing. One interrupt line combines per-character events with queue-level conditions.

Top module: `fifo_uart`

## Requirements
- R1: After reset the status word reads 0x00000006 (shift register idle at bit 1, transmit queue empty at bit 2, all counts zero), control and divider read 0, `irq` is low and `txd` is high.
- R2: A write to offset 0x00 pushes bits 7:0 into the 32-entry transmit queue. Status bits 25:20 give its count, bit 2 is set when the count is 0, bit 7 is set when the count is 16 or more, and bit 9 is set when the count is 32. A write to a full queue is dropped.
- R3: Each character on `txd` is a low start bit, then the data LSB first, then a parity bit if control bit 5 is set (even parity when control bit 4 is 0, odd when it is 1), then a high stop bit. Each bit lasts 8 × divider clock cycles.
- R4: A divider value of 0 (offset 0x0C, bits 11:0) stops all serial progress. A frame in flight holds, and no further entry leaves the transmit queue.
- R5: With control bit 7 set, transmitted characters are received internally in order and `txd` stays high.
- R6: A read of offset 0x00 pops the oldest received byte. Status bit 0 flags a non-empty receive queue, bits 31:26 give its count, bit 8 is set at 16 or more entries and bit 10 is set at 32.
- R7: A character completed while the receive queue holds 32 entries is dropped, and status bit 4 (overrun) is set.
- R8: A parity mismatch sets status bit 5, and the character is still stored.
- R9: A low stop bit after non-zero data sets status bit 6 (framing), and the character is still stored.
- R10: A frame of all-zero data with a low stop bit sets status bit 3 (break) and stores nothing.
- R11: A write to offset 0x04 clears each of status bits 3 to 6 whose written bit is 0. Bits written as 1 leave the flag unchanged.
- R12: `irq` is registered and is the OR of four terms: a one-cycle pulse per stored character (control bit 2), a one-cycle pulse per finished transmitted frame (control bit 3), a level while the transmit count is below 16 (control bit 9), and a level while the receive count is 16 or more (control bit 10).
- R13: With control bit 1 clear, no frame starts and the transmit queue keeps its content. With control bit 0 clear, the line is ignored and nothing is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_sel | input | 1 | Register access strobe, one access per cycle |
| reg_wr | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 4 | Byte offset; bits 3:2 select the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from the address |
| txd | output | 1 | Serial output, idle high |
| rxd | input | 1 | Serial input, idle high, synchronised internally |
| irq | output | 1 | Interrupt request |

## Verification
The in-line assertions assume that `rxd` returns high between frames after any low stop bit. They also assume that software changes the divider only to stop a frame or to restart a stopped frame, and never to reshape one mid-bit. The stimulus drives serial input at exactly eight divider periods per bit and leaves at least two idle bit times after each frame. It issues at most one register access per cycle and rewrites the divider only while the serial logic is frozen or idle. Overrun and break are reached with legal frames only: a full queue plus one more character, and a zero frame with its stop bit held low.

// File: rtl/uart_pkg.sv
package uart_pkg;
  localparam int DATA_W = 8;
  localparam int REG_W  = 32;

  localparam logic [1:0] RSEL_DATA = 2'd0;
  localparam logic [1:0] RSEL_STAT = 2'd1;
  localparam logic [1:0] RSEL_CTRL = 2'd2;
  localparam logic [1:0] RSEL_DIV  = 2'd3;

  localparam int ST_RDY     = 0;
  localparam int ST_SHEMPTY = 1;
  localparam int ST_TEMPTY  = 2;
  localparam int ST_BRK     = 3;
  localparam int ST_OVR     = 4;
  localparam int ST_PAR     = 5;
  localparam int ST_FRM     = 6;
  localparam int ST_THALF   = 7;
  localparam int ST_RHALF   = 8;
  localparam int ST_TFULL   = 9;
  localparam int ST_RFULL   = 10;
  localparam int ST_TCNT    = 20;
  localparam int ST_RCNT    = 26;
  localparam int CNT_FLD_W  = 6;

  localparam int CT_RXEN  = 0;
  localparam int CT_TXEN  = 1;
  localparam int CT_RXIE  = 2;
  localparam int CT_TXIE  = 3;
  localparam int CT_ODD   = 4;
  localparam int CT_PAREN = 5;
  localparam int CT_LOOP  = 7;
  localparam int CT_TLIE  = 9;
  localparam int CT_RLIE  = 10;

  typedef struct packed {
    logic rl_ie;
    logic tl_ie;
    logic loop;
    logic par_en;
    logic par_odd;
    logic tx_ie;
    logic rx_ie;
    logic tx_en;
    logic rx_en;
  } ctrl_t;

  typedef enum logic [2:0] {
    RX_IDLE, RX_START, RX_DATA, RX_PAR, RX_STOP, RX_WAITHI
  } rx_state_e;
endpackage

// File: rtl/uart_fifo.sv
module uart_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 32,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH) + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [W-1:0]  in_data,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [W-1:0]  out_data,
  output logic [CW-1:0] count
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic          do_push, do_pop;

  assign in_ready  = count < CW'(DEPTH);
  assign out_valid = count != '0;
  assign out_data  = mem[rp];
  assign do_push   = in_valid && in_ready;
  assign do_pop    = out_valid && out_ready;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (do_push) wp <= nxt(wp);
      if (do_pop)  rp <= nxt(rp);
      if (do_push && !do_pop)      count <= count + 1'b1;
      else if (do_pop && !do_push) count <= count - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= in_data;
  end

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (count == $past(count)) || (count == $past(count) + 1'b1) || (count == $past(count) - 1'b1))
    else $error("fifo count jumped"); // R2
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (count == CW'(DEPTH) && in_valid && !out_ready) |=> count == CW'(DEPTH))
    else $error("fifo overflowed"); // R7
endmodule

// File: rtl/uart_baud.sv
module uart_baud #(
  parameter int SCALE_W = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [SCALE_W-1:0] scale,
  output logic               tick
);
  logic [SCALE_W-1:0] cnt;
  logic               wrap;

  assign wrap = (scale != '0) && (cnt >= scale - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else begin
      tick <= wrap;
      if (scale == '0 || wrap) cnt <= '0;
      else                     cnt <= cnt + 1'b1;
    end
  end

  AST_SCALE_ZERO_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (scale == '0) |=> !tick) else $error("tick with divider 0"); // R4
endmodule

// File: rtl/uart_tx.sv
module uart_tx #(
  parameter int OSR = 8,
  localparam int SW = $clog2(OSR)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       en,
  input  logic       par_en,
  input  logic       par_odd,
  input  logic       in_valid,
  output logic       in_ready,
  input  logic [7:0] in_data,
  output logic       line,
  output logic       busy,
  output logic       done
);
  localparam int FL = 11;
  logic [FL-1:0] sh;
  logic [SW-1:0] sub;
  logic [3:0]    bitn, last;
  logic          pbit;

  assign in_ready = en && !busy;
  assign line     = busy ? sh[0] : 1'b1;
  assign pbit     = par_odd ? ~(^in_data) : ^in_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      done <= 1'b0;
      sh   <= '1;
      sub  <= '0;
      bitn <= '0;
      last <= '0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (in_valid && en) begin
          busy <= 1'b1;
          sub  <= '0;
          bitn <= '0;
          if (par_en) begin
            sh   <= {1'b1, pbit, in_data, 1'b0};
            last <= 4'd10;
          end else begin
            sh   <= {2'b11, in_data, 1'b0};
            last <= 4'd9;
          end
        end
      end else if (tick) begin
        if (sub == SW'(OSR - 1)) begin
          sub <= '0;
          sh  <= {1'b1, sh[FL-1:1]};
          if (bitn == last) begin
            busy <= 1'b0;
            done <= 1'b1;
          end else begin
            bitn <= bitn + 1'b1;
          end
        end else begin
          sub <= sub + 1'b1;
        end
      end
    end
  end

  AST_START_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !line) else $error("frame did not open low"); // R3
endmodule

// File: rtl/uart_rx.sv
module uart_rx import uart_pkg::*; #(
  parameter int OSR = 8,
  localparam int SW = $clog2(OSR)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       en,
  input  logic       par_en,
  input  logic       par_odd,
  input  logic       line,
  output logic       push_valid,
  output logic [7:0] push_data,
  output logic       brk,
  output logic       perr,
  output logic       ferr
);
  rx_state_e     st;
  logic [SW-1:0] sub;
  logic [2:0]    bitn;
  logic [7:0]    data;
  logic          pbit, at_end;

  assign at_end = tick && (sub == SW'(OSR - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= RX_IDLE;
      sub <= '0;
      bitn <= '0;
      data <= '0;
      pbit <= 1'b0;
      push_valid <= 1'b0;
      push_data <= '0;
      brk <= 1'b0;
      perr <= 1'b0;
      ferr <= 1'b0;
    end else begin
      push_valid <= 1'b0;
      brk <= 1'b0;
      perr <= 1'b0;
      ferr <= 1'b0;
      if (!en) begin
        st <= RX_IDLE;
      end else begin
        unique case (st)
          RX_IDLE: if (tick && !line) begin
            st  <= RX_START;
            sub <= '0;
          end
          RX_START: if (tick) begin
            if (sub == SW'(OSR / 2 - 1)) begin
              sub  <= '0;
              bitn <= '0;
              st   <= line ? RX_IDLE : RX_DATA;
            end else begin
              sub <= sub + 1'b1;
            end
          end
          RX_DATA: if (at_end) begin
            sub  <= '0;
            data <= {line, data[7:1]};
            bitn <= bitn + 1'b1;
            if (bitn == 3'd7) st <= par_en ? RX_PAR : RX_STOP;
          end else if (tick) begin
            sub <= sub + 1'b1;
          end
          RX_PAR: if (at_end) begin
            sub  <= '0;
            pbit <= line;
            st   <= RX_STOP;
          end else if (tick) begin
            sub <= sub + 1'b1;
          end
          RX_STOP: if (at_end) begin
            sub <= '0;
            if (!line && data == '0) begin
              brk <= 1'b1;
            end else begin
              push_valid <= 1'b1;
              push_data  <= data;
              ferr       <= !line;
              perr       <= par_en && (pbit != (par_odd ? ~(^data) : ^data));
            end
            st <= line ? RX_IDLE : RX_WAITHI;
          end else if (tick) begin
            sub <= sub + 1'b1;
          end
          RX_WAITHI: if (line) st <= RX_IDLE;
          default: st <= RX_IDLE;
        endcase
      end
    end
  end

  AST_BREAK_NO_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
    brk |-> !push_valid) else $error("break stored a byte"); // R10
endmodule

// File: rtl/fifo_uart.sv
module fifo_uart import uart_pkg::*; #(
  parameter int DEPTH   = 32,
  parameter int SCALE_W = 12,
  parameter int OSR     = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_sel,
  input  logic        reg_wr,
  input  logic [3:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        txd,
  input  logic        rxd,
  output logic        irq
);
  localparam int CW   = $clog2(DEPTH) + 1;
  localparam int HALF = DEPTH / 2;

  ctrl_t              ctrl;
  logic [SCALE_W-1:0] scale;
  logic               f_brk, f_ovr, f_par, f_frm;
  logic [1:0]         rsel;
  logic               wr_data, rd_data, wr_stat, wr_ctrl, wr_div;

  assign rsel    = reg_addr[3:2];
  assign wr_data = reg_sel && reg_wr && rsel == RSEL_DATA;
  assign rd_data = reg_sel && !reg_wr && rsel == RSEL_DATA;
  assign wr_stat = reg_sel && reg_wr && rsel == RSEL_STAT;
  assign wr_ctrl = reg_sel && reg_wr && rsel == RSEL_CTRL;
  assign wr_div  = reg_sel && reg_wr && rsel == RSEL_DIV;

  // transmit path
  logic          tq_in_ready, tq_valid, tq_ready;
  logic [7:0]    tq_data;
  logic [CW-1:0] tq_cnt;
  logic          tick, tx_line, tx_busy, tx_done;

  uart_fifo #(.W(DATA_W), .DEPTH(DEPTH)) u_txq (
    .clk(clk), .rst_n(rst_n),
    .in_valid(wr_data), .in_ready(tq_in_ready), .in_data(reg_wdata[7:0]),
    .out_valid(tq_valid), .out_ready(tq_ready), .out_data(tq_data),
    .count(tq_cnt));

  uart_baud #(.SCALE_W(SCALE_W)) u_baud (
    .clk(clk), .rst_n(rst_n), .scale(scale), .tick(tick));

  uart_tx #(.OSR(OSR)) u_tx (
    .clk(clk), .rst_n(rst_n), .tick(tick), .en(ctrl.tx_en),
    .par_en(ctrl.par_en), .par_odd(ctrl.par_odd),
    .in_valid(tq_valid), .in_ready(tq_ready), .in_data(tq_data),
    .line(tx_line), .busy(tx_busy), .done(tx_done));

  // receive path
  logic          s1, s2, rx_src;
  logic          rx_pv, rx_brk, rx_perr, rx_ferr;
  logic [7:0]    rx_pd;
  logic          rq_in_ready, rq_valid;
  logic [7:0]    rq_data;
  logic [CW-1:0] rq_cnt;

  assign rx_src = ctrl.loop ? tx_line : rxd;
  assign txd    = ctrl.loop ? 1'b1 : tx_line;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= 1'b1;
      s2 <= 1'b1;
    end else begin
      s1 <= rx_src;
      s2 <= s1;
    end
  end

  uart_rx #(.OSR(OSR)) u_rx (
    .clk(clk), .rst_n(rst_n), .tick(tick), .en(ctrl.rx_en),
    .par_en(ctrl.par_en), .par_odd(ctrl.par_odd), .line(s2),
    .push_valid(rx_pv), .push_data(rx_pd),
    .brk(rx_brk), .perr(rx_perr), .ferr(rx_ferr));

  uart_fifo #(.W(DATA_W), .DEPTH(DEPTH)) u_rxq (
    .clk(clk), .rst_n(rst_n),
    .in_valid(rx_pv), .in_ready(rq_in_ready), .in_data(rx_pd),
    .out_valid(rq_valid), .out_ready(rd_data), .out_data(rq_data),
    .count(rq_cnt));

  // registers and sticky flags
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl  <= '0;
      scale <= '0;
      f_brk <= 1'b0;
      f_ovr <= 1'b0;
      f_par <= 1'b0;
      f_frm <= 1'b0;
      irq   <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        ctrl.rx_en   <= reg_wdata[CT_RXEN];
        ctrl.tx_en   <= reg_wdata[CT_TXEN];
        ctrl.rx_ie   <= reg_wdata[CT_RXIE];
        ctrl.tx_ie   <= reg_wdata[CT_TXIE];
        ctrl.par_odd <= reg_wdata[CT_ODD];
        ctrl.par_en  <= reg_wdata[CT_PAREN];
        ctrl.loop    <= reg_wdata[CT_LOOP];
        ctrl.tl_ie   <= reg_wdata[CT_TLIE];
        ctrl.rl_ie   <= reg_wdata[CT_RLIE];
      end
      if (wr_div) scale <= reg_wdata[SCALE_W-1:0];
      f_brk <= rx_brk  || (f_brk && !(wr_stat && !reg_wdata[ST_BRK]));
      f_ovr <= (rx_pv && !rq_in_ready) || (f_ovr && !(wr_stat && !reg_wdata[ST_OVR]));
      f_par <= (rx_perr && rq_in_ready) || (f_par && !(wr_stat && !reg_wdata[ST_PAR]));
      f_frm <= (rx_ferr && rq_in_ready) || (f_frm && !(wr_stat && !reg_wdata[ST_FRM]));
      irq   <= (ctrl.rx_ie && rx_pv && rq_in_ready) || (ctrl.tx_ie && tx_done)
            || (ctrl.tl_ie && tq_cnt < CW'(HALF)) || (ctrl.rl_ie && rq_cnt >= CW'(HALF));
    end
  end

  logic [31:0] stat_w, ctrl_w;
  always_comb begin
    stat_w = '0;
    stat_w[ST_RDY]     = rq_valid;
    stat_w[ST_SHEMPTY] = !tx_busy;
    stat_w[ST_TEMPTY]  = tq_cnt == '0;
    stat_w[ST_BRK]     = f_brk;
    stat_w[ST_OVR]     = f_ovr;
    stat_w[ST_PAR]     = f_par;
    stat_w[ST_FRM]     = f_frm;
    stat_w[ST_THALF]   = tq_cnt >= CW'(HALF);
    stat_w[ST_RHALF]   = rq_cnt >= CW'(HALF);
    stat_w[ST_TFULL]   = tq_cnt == CW'(DEPTH);
    stat_w[ST_RFULL]   = rq_cnt == CW'(DEPTH);
    stat_w[ST_TCNT +: CNT_FLD_W] = CNT_FLD_W'(tq_cnt);
    stat_w[ST_RCNT +: CNT_FLD_W] = CNT_FLD_W'(rq_cnt);
    ctrl_w = '0;
    ctrl_w[CT_RXEN]  = ctrl.rx_en;
    ctrl_w[CT_TXEN]  = ctrl.tx_en;
    ctrl_w[CT_RXIE]  = ctrl.rx_ie;
    ctrl_w[CT_TXIE]  = ctrl.tx_ie;
    ctrl_w[CT_ODD]   = ctrl.par_odd;
    ctrl_w[CT_PAREN] = ctrl.par_en;
    ctrl_w[CT_LOOP]  = ctrl.loop;
    ctrl_w[CT_TLIE]  = ctrl.tl_ie;
    ctrl_w[CT_RLIE]  = ctrl.rl_ie;
  end

  always_comb begin
    unique case (rsel)
      RSEL_DATA: reg_rdata = rq_valid ? {24'd0, rq_data} : '0;
      RSEL_STAT: reg_rdata = stat_w;
      RSEL_CTRL: reg_rdata = ctrl_w;
      default:   reg_rdata = 32'(scale);
    endcase
  end

  logic unused_bits;
  assign unused_bits = ^{reg_addr[1:0], reg_wdata[31:11], tq_in_ready};

  AST_OVR_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_pv && !rq_in_ready) |=> f_ovr) else $error("overrun not flagged"); // R7
  AST_RXLVL_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl.rl_ie && rq_cnt >= CW'(HALF)) |=> irq) else $error("level irq missing"); // R12
endmodule

// File: tb/tb_fifo_uart.sv
module tb_fifo_uart;
  localparam int CLK_PERIOD = 10;
  localparam int BITC = 16; // divider 2 x 8 ticks

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_sel = 1'b0, reg_wr = 1'b0, rxd = 1'b1;
  logic [3:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic txd, irq;
  int nchk = 0, nfail = 0;
  logic [9:0] txq[$];
  logic [7:0] rxq[$];

  always #(CLK_PERIOD / 2) clk = ~clk;

  fifo_uart dut (.clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .txd(txd), .rxd(rxd), .irq(irq));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); reg_sel = 1; reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_sel = 0; reg_wr = 0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk); reg_sel = 1; reg_wr = 0; reg_addr = a; #1 d = reg_rdata;
    @(negedge clk); reg_sel = 0;
  endtask

  task automatic wait_rcnt(input int n);
    logic [31:0] s;
    for (int i = 0; i < 4000; i++) begin
      rd(4, s);
      if (int'(s[31:26]) == n) return;
    end
  endtask

  task automatic pop_chk(input string tag);
    logic [31:0] d;
    logic [7:0] e;
    rd(0, d);
    e = (rxq.size() > 0) ? rxq.pop_front() : 8'hxx;
    chk(tag, d, {24'd0, e});
  endtask

  task automatic send_rx(input logic [7:0] b, input bit pe, input bit pv, input bit stp);
    @(negedge clk); rxd = 0; repeat (BITC) @(negedge clk);
    for (int i = 0; i < 8; i++) begin rxd = b[i]; repeat (BITC) @(negedge clk); end
    if (pe) begin rxd = pv; repeat (BITC) @(negedge clk); end
    rxd = stp; repeat (BITC) @(negedge clk);
    rxd = 1; repeat (2 * BITC) @(negedge clk);
  endtask

  // TXD monitor: decodes frames and compares to the scoreboard queue (R3)
  initial begin
    forever begin
      logic [9:0] e;
      logic [7:0] d;
      logic p, s0;
      @(negedge txd);
      if (rst_n) begin
        e = (txq.size() > 0) ? txq.pop_front() : 10'h3ff;
        repeat (8) @(negedge clk); s0 = txd;
        for (int i = 0; i < 8; i++) begin repeat (BITC) @(negedge clk); d[i] = txd; end
        if (e[9]) begin repeat (BITC) @(negedge clk); p = txd; chk("R3 parity", p, e[8]); end
        repeat (BITC) @(negedge clk);
        chk("R3 stop", txd, 1);
        chk("R3 start", s0, 0);
        chk("R3 data", d, e[7:0]);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    nfail++; nchk++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    logic [31:0] s;
    bit seen;
    repeat (3) @(negedge clk); rst_n = 1;
    // R1
    rd(4, s); chk("R1 status", s, 32'h6);
    rd(8, s); chk("R1 ctrl", s, 0);
    rd(12, s); chk("R1 divider", s, 0);
    chk("R1 irq", irq, 0); chk("R1 txd", txd, 1);
    // R2 fill with transmitter off
    for (int i = 0; i < 33; i++) begin
      wr(0, i);
      rd(4, s);
      if (i == 14) begin chk("R2 cnt15", s[25:20], 15); chk("R2 half off", s[7], 0); end
      if (i == 15) chk("R2 half on", s[7], 1);
      if (i == 31) begin chk("R2 full", s[9], 1); chk("R2 not empty", s[2], 0); end
      if (i == 32) chk("R2 drop when full", s[25:20], 32);
    end
    @(negedge clk); rst_n = 0; @(negedge clk); rst_n = 1;
    rd(4, s); chk("R1 status after reset", s, 32'h6);
    // R12 transmit level interrupt
    wr(8, 32'h200); @(negedge clk); chk("R12 tx level irq", irq, 1);
    wr(8, 0); @(negedge clk); chk("R12 tx level irq off", irq, 0);
    // R3 frames
    wr(12, 2);
    wr(8, 32'h22); txq.push_back({1'b1, ^8'hA5, 8'hA5}); wr(0, 32'hA5);
    repeat (300) @(negedge clk);
    wr(8, 32'h32); txq.push_back({1'b1, ~(^8'h3C), 8'h3C}); wr(0, 32'h3C);
    repeat (300) @(negedge clk);
    // R12 tx done pulse, no parity
    wr(8, 32'h0A); txq.push_back({2'b00, 8'h81}); wr(0, 32'h81);
    seen = 0;
    for (int i = 0; i < 400 && !seen; i++) begin @(negedge clk); if (irq) seen = 1; end
    chk("R12 tx done pulse", seen, 1);
    @(negedge clk); chk("R12 tx pulse one cycle", irq, 0);
    repeat (40) @(negedge clk);
    chk("R3 all frames seen", txq.size(), 0);
    // R4 divider zero freezes, R5 loopback
    wr(12, 0); wr(8, 32'h83);
    wr(0, 32'h5A); rxq.push_back(8'h5A);
    wr(0, 32'h77); rxq.push_back(8'h77);
    repeat (300) @(negedge clk);
    rd(4, s);
    chk("R4 tx count held", s[25:20], 1);
    chk("R4 shifter held busy", s[1], 0);
    chk("R4 nothing received", s[31:26], 0);
    chk("R5 txd high in loopback", txd, 1);
    wr(12, 2);
    wait_rcnt(2);
    pop_chk("R5 loop byte0"); pop_chk("R5 loop byte1");
    // R6 stream with even parity and receive level irq
    wr(8, 32'h4A3);
    for (int i = 0; i < 20; i++) begin
      logic [7:0] b;
      b = 8'(i * 37 + 3);
      wr(0, {24'd0, b}); rxq.push_back(b);
    end
    wait_rcnt(20);
    rd(4, s);
    chk("R6 count", s[31:26], 20); chk("R6 ready", s[0], 1);
    chk("R6 half", s[8], 1); chk("R6 not full", s[10], 0);
    chk("R12 rx level irq", irq, 1);
    for (int i = 0; i < 20; i++) pop_chk("R6 order");
    rd(4, s); chk("R6 empty", s[0], 0); chk("R6 count zero", s[31:26], 0);
    @(negedge clk); chk("R12 rx level irq off", irq, 0);
    // R8 parity error on external line
    wr(8, 32'h21);
    send_rx(8'h0F, 1, 1, 1); rxq.push_back(8'h0F);
    rd(4, s); chk("R8 parity flag", s[5], 1); chk("R8 no frame flag", s[6], 0);
    pop_chk("R8 byte kept");
    // R9 framing error
    send_rx(8'h42, 1, 0, 0); rxq.push_back(8'h42);
    rd(4, s); chk("R9 framing flag", s[6], 1);
    pop_chk("R9 byte kept");
    // R10 break
    wr(8, 32'h01);
    send_rx(8'h00, 0, 0, 0);
    rd(4, s); chk("R10 break flag", s[3], 1); chk("R10 nothing stored", s[31:26], 0);
    // R11 selective clear
    wr(4, 32'hFFFF_FFDF);
    rd(4, s); chk("R11 cleared bit", s[5], 0); chk("R11 kept frame", s[6], 1);
    chk("R11 kept break", s[3], 1);
    wr(4, 0); rd(4, s); chk("R11 all clear", s[6:3], 0);
    // R7 overrun
    for (int i = 0; i < 33; i++) begin
      send_rx(8'(8'h10 + i), 0, 0, 1);
      if (i < 32) rxq.push_back(8'(8'h10 + i));
    end
    rd(4, s);
    chk("R7 full count", s[31:26], 32); chk("R7 full flag", s[10], 1);
    chk("R7 overrun flag", s[4], 1);
    for (int i = 0; i < 32; i++) pop_chk("R7 drop newest");
    // R12 receive character pulse
    wr(8, 32'h05); seen = 0;
    fork
      send_rx(8'h6B, 0, 0, 1);
      for (int i = 0; i < 260 && !seen; i++) begin @(negedge clk); if (irq) seen = 1; end
    join
    rxq.push_back(8'h6B);
    chk("R12 rx char pulse", seen, 1);
    pop_chk("R12 rx byte");
    // R13 enables off
    wr(8, 0);
    send_rx(8'h99, 0, 0, 1);
    rd(4, s); chk("R13 rx disabled", s[31:26], 0);
    wr(0, 32'h11);
    repeat (300) @(negedge clk);
    rd(4, s); chk("R13 tx held", s[25:20], 1); chk("R13 txd idle", txd, 1);
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule